// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt output to a processor on an 8-bit bus. A rising edge on a request line latches that line into a pending register. A mask register hides chosen lines from arbitration. A priority resolver selects the best unmasked pending line. The output is raised only when that line outranks every level that is already being serviced, so service nests by priority.

When the processor acknowledges, the winning line moves from pending to in-service, and a vector byte naming it is presented. Software ends service with end-of-interrupt commands. The priority order is either fixed (line 0 highest), rotated automatically after each serviced level, or rotated on explicit software command.

The processor uses a chip select, active-low read and write strobes, one address bit and an 8-bit data bus. Each cycle in which chip select and write are both low performs one write on the rising clock edge. Reads are combinational while chip select and read are both low.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, in-service and mask registers are zero. `irq_out` is low and `vec` is 0x00. The mode is fixed priority with line 0 highest, and the read selection is the pending register.
- R2: A 0-to-1 transition seen on `irq_in[i]` at a clock edge sets pending bit i. A line held high sets its bit only once. The pending register is read at address 0 when the read selection is 0.
- R3: A write at address 1 loads the mask register, and a read at address 1 returns it. A pending line whose mask bit is 1 takes no part in arbitration and does not raise `irq_out`.
- R4: `irq_out` is high exactly when some unmasked pending line has higher priority than every in-service level.
- R5: An `ack` pulse in a cycle with `irq_out` high clears the winning line's pending bit and sets its in-service bit. From the next cycle, `vec` shows {base[4:0], level[2:0]}. An `ack` while `irq_out` is low changes nothing.
- R6: Command 001xxxxx (address 0) clears the highest-priority in-service bit, if any is set.
- R7: In automatic-rotation mode, command 001xxxxx also makes the level it cleared the lowest priority. The level after it becomes the highest.
- R8: Command 110xxlll makes level lll the lowest priority in either rotation mode, and is ignored in fixed mode. In specific-rotation mode, command 001xxxxx does not rotate.
- R9: Command 111xxlll clears in-service bit lll. In either rotation mode it also makes lll the lowest priority.
- R10: Command 100xxxmm selects the mode: mm=01 automatic rotation, mm=10 specific rotation, any other value fixed. Any mode command resets the order so that line 0 is highest.
- R11: Command 010xxxxs sets the read selection: s=0 selects pending, s=1 selects in-service. Command 101bbbbb sets the vector base. Commands 000xxxxx and 011xxxxx are ignored.
- R12: `dout` is 0x00 whenever chip select or read is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | 0: command / pending or in-service; 1: mask |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not reading |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq_out | output | 1 | Interrupt to the processor |
| vec | output | 8 | Vector of the last acknowledged level |

## Verification
A wrong pending, mask or in-service bit shows on `irq_out` in the very next cycle, because the output is decoded straight from those registers. A wrong rotation pointer stays hidden until two requests compete. It then appears as a wrong level in `vec` one cycle after the acknowledge. The bench therefore compares `irq_out` and `vec` against a behavioural model on every cycle. It also reads the three registers back after each command, so a stale bit is caught before the next stimulus.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               addr,
  input  logic [7:0]         din,
  output logic [7:0]         dout,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               ack,
  output logic               irq_out,
  output logic [7:0]         vec
);
  localparam int LW = $clog2(NUM_IRQ);
  localparam int BW = 8 - LW;

  typedef enum logic [1:0] {MD_FIXED = 2'd0, MD_AUTO = 2'd1, MD_SPEC = 2'd2} mode_t;

  logic [NUM_IRQ-1:0] irr, isr, imr, prev;
  logic [LW-1:0]      lo;
  mode_t              mode;
  logic               sel;
  logic [BW-1:0]      base;

  function automatic logic [LW:0] pick(input logic [NUM_IRQ-1:0] v, input logic [LW-1:0] low);
    logic [LW-1:0] idx;
    pick = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      idx = low + LW'(1) + LW'(k);
      if (v[idx]) pick = {1'b1, idx};
    end
  endfunction

  logic          p_ok, s_ok;
  logic [LW-1:0] p_lvl, s_lvl, p_rank, s_rank;

  assign {p_ok, p_lvl} = pick(irr & ~imr, lo);
  assign {s_ok, s_lvl} = pick(isr, lo);
  assign p_rank  = p_lvl - lo - LW'(1);
  assign s_rank  = s_lvl - lo - LW'(1);
  assign irq_out = p_ok && (!s_ok || p_rank < s_rank);

  wire          wr_en  = !cs_n && !wr_n;
  wire          rd_en  = !cs_n && !rd_n;
  wire          cmd_en = wr_en && !addr;
  wire [2:0]    op     = din[7:5];
  wire [LW-1:0] arg    = din[LW-1:0];
  wire          take   = ack && irq_out;
  wire          rot_ok = mode != MD_FIXED;
  wire          eoi_ns = cmd_en && op == 3'b001;
  wire          eoi_sp = cmd_en && op == 3'b111;

  wire [NUM_IRQ-1:0] set_v = take ? (NUM_IRQ'(1) << p_lvl) : '0;
  wire [NUM_IRQ-1:0] clr_v = (eoi_ns && s_ok) ? (NUM_IRQ'(1) << s_lvl) :
                             eoi_sp ? (NUM_IRQ'(1) << arg) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr  <= '0;
      isr  <= '0;
      imr  <= '0;
      prev <= '0;
      lo   <= '1;
      mode <= MD_FIXED;
      sel  <= 1'b0;
      base <= '0;
      vec  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= (irr & ~set_v) | (irq_in & ~prev);
      isr  <= (isr | set_v) & ~clr_v;
      if (take) vec <= {base, p_lvl};
      if (wr_en && addr) imr <= din[NUM_IRQ-1:0];
      if (cmd_en) begin
        case (op)
          3'b010: sel <= din[0];
          3'b101: base <= din[BW-1:0];
          3'b100: begin
            lo <= '1;
            case (din[1:0])
              2'b01:   mode <= MD_AUTO;
              2'b10:   mode <= MD_SPEC;
              default: mode <= MD_FIXED;
            endcase
          end
          3'b110, 3'b111: if (rot_ok) lo <= arg;
          3'b001: if (s_ok && mode == MD_AUTO) lo <= s_lvl;
          default: ;
        endcase
      end
    end
  end

  assign dout = !rd_en ? 8'h00 : addr ? 8'(imr) : sel ? 8'(isr) : 8'(irr);
endmodule

module prio_irq_ctrl_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 addr,
  input logic [2:0]           op,
  input logic                 ack,
  input logic                 irq_out,
  input logic [7:0]           dout,
  input logic [N-1:0]         irr,
  input logic [N-1:0]         isr,
  input logic [N-1:0]         imr,
  input logic [$clog2(N)-1:0] lo,
  input logic [1:0]           mode
);
  wire cmd_w = !cs_n && !wr_n && !addr;

  p_irq_has_pending_r4: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ((irr & ~imr) != '0));

  p_ack_adds_service_r5: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_out && !cmd_w) |=> ($countones(isr) == $past($countones(isr)) + 1));

  p_eoi_drops_service_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && op == 3'b001 && isr != '0 && !ack) |=> ($countones(isr) == $past($countones(isr)) - 1));

  p_fixed_order_r10: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (lo == '1));

  p_idle_bus_r12: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |-> (dout == 8'h00));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .op(din[7:5]), .ack(ack), .irq_out(irq_out), .dout(dout),
  .irr(irr), .isr(isr), .imr(imr), .lo(lo), .mode(mode)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 0, rst = 1;
  logic       cs_n = 1, rd_n = 1, wr_n = 1, addr = 0, ack = 0;
  logic [7:0] din = 0, irq_in = 0;
  logic [7:0] dout, vec;
  logic       irq_out;
  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_dut (.clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .irq_in(irq_in), .ack(ack),
    .irq_out(irq_out), .vec(vec));

  bit [7:0] m_irr, m_isr, m_imr, m_prev, m_vec;
  bit [4:0] m_base;
  int m_low, m_mode;
  bit m_sel;

  function automatic int best(bit [7:0] v, int low);
    for (int k = 0; k < 8; k++) if (v[(low + 1 + k) % 8]) return (low + 1 + k) % 8;
    return -1;
  endfunction

  function automatic int rnk(int l, int low);
    return (l - low - 1 + 16) % 8;
  endfunction

  function automatic bit m_irq();
    int p = best(m_irr & ~m_imr, m_low);
    int s = best(m_isr, m_low);
    return p >= 0 && (s < 0 || rnk(p, m_low) < rnk(s, m_low));
  endfunction

  always @(posedge clk) begin
    bit [7:0] setv, clrv;
    int p, s;
    if (rst) begin
      m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_vec = 0;
      m_base = 0; m_low = 7; m_mode = 0; m_sel = 0;
    end else begin
      setv = 0; clrv = 0;
      p = best(m_irr & ~m_imr, m_low);
      s = best(m_isr, m_low);
      if (ack && m_irq()) begin
        setv[p] = 1;
        m_vec = {m_base, 3'(p)};
      end
      if (!cs_n && !wr_n) begin
        if (addr) m_imr = din;
        else case (din[7:5])
          3'd1: if (s >= 0) begin clrv[s] = 1; if (m_mode == 1) m_low = s; end
          3'd2: m_sel = din[0];
          3'd4: begin m_mode = (din[1:0] == 1) ? 1 : (din[1:0] == 2) ? 2 : 0; m_low = 7; end
          3'd5: m_base = din[4:0];
          3'd6: if (m_mode != 0) m_low = din[2:0];
          3'd7: begin clrv[din[2:0]] = 1; if (m_mode != 0) m_low = din[2:0]; end
          default: ;
        endcase
      end
      m_irr = (m_irr & ~setv) | (irq_in & ~m_prev);
      m_isr = (m_isr | setv) & ~clrv;
      m_prev = irq_in;
    end
  end

  always @(negedge clk) if (!rst) begin
    checks++;
    if (irq_out !== m_irq()) begin
      errors++;
      $display("FAIL %s/R4 irq_out act=%0b exp=%0b", phase, irq_out, m_irq());
    end
    checks++;
    if (vec !== m_vec) begin
      errors++;
      $display("FAIL %s/R5 vec act=%02h exp=%02h", phase, vec, m_vec);
    end
  end

  task automatic wr(bit a, bit [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(bit a);
    bit [7:0] e;
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1;
    e = a ? m_imr : (m_sel ? m_isr : m_irr);
    checks++;
    if (dout !== e) begin
      errors++;
      $display("FAIL %s read a=%0b act=%02h exp=%02h", phase, a, dout, e);
    end
    cs_n = 1; rd_n = 1;
  endtask

  task automatic rd_all();
    wr(0, 8'h40); rd(0);
    wr(0, 8'h41); rd(0);
    rd(1);
  endtask

  task automatic raise(bit [7:0] m);
    @(negedge clk); irq_in = irq_in | m;
    @(negedge clk); irq_in = irq_in & ~m;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    phase = "R1"; idle(1);
    expect_bit("R1 irq_out low after reset", irq_out, 1'b0);
    rd(0); rd(1);
    raise(8'h81); idle(1); do_ack(); idle(1);
    expect_bit("R1 line 0 wins first", vec == 8'h00, 1'b1);
    wr(0, 8'h20); do_ack(); wr(0, 8'h20); idle(1); rd_all();

    phase = "R2";
    @(negedge clk); irq_in[3] = 1; idle(4); irq_in[3] = 0;
    rd_all();
    expect_bit("R2 held line raises once", irq_out, 1'b1);

    phase = "R3";
    wr(1, 8'h08); idle(1);
    expect_bit("R3 masked line silent", irq_out, 1'b0);
    rd_all(); wr(1, 8'h00); idle(1);

    phase = "R11";
    wr(0, 8'h15); wr(0, 8'h60);
    wr(0, 8'hB5); rd_all();

    phase = "R5";
    do_ack(); idle(1);
    expect_bit("R5 vector base and level", vec == 8'hAB, 1'b1);
    rd_all();

    phase = "R4";
    raise(8'h20); idle(1);
    expect_bit("R4 lower line blocked by service", irq_out, 1'b0);
    do_ack(); idle(1); rd_all();
    raise(8'h02); idle(1);
    expect_bit("R4 higher line nests", irq_out, 1'b1);
    do_ack(); rd_all();

    phase = "R6";
    wr(0, 8'h20); rd_all();
    wr(0, 8'h20); idle(1); rd_all();
    do_ack(); wr(0, 8'h20); rd_all();

    phase = "R10";
    wr(0, 8'h81); rd_all();

    phase = "R7";
    raise(8'h04); do_ack(); wr(0, 8'h20);
    raise(8'h12); idle(1); do_ack(); idle(1);
    expect_bit("R7 rotated winner is 4", vec[2:0] == 3'd4, 1'b1);
    wr(0, 8'h20); raise(8'h80); do_ack(); wr(0, 8'h20); rd_all();

    phase = "R8";
    wr(0, 8'h82);
    wr(0, 8'hC4);
    raise(8'h61); idle(1); do_ack(); idle(1);
    expect_bit("R8 level 5 highest", vec[2:0] == 3'd5, 1'b1);
    wr(0, 8'h20); do_ack(); wr(0, 8'h20); do_ack(); wr(0, 8'h20);
    rd_all();
    wr(0, 8'h80); wr(0, 8'hC3);
    raise(8'h11); idle(1); do_ack(); idle(1);
    expect_bit("R8 fixed mode ignores rotate", vec[2:0] == 3'd0, 1'b1);
    wr(0, 8'h20); do_ack(); wr(0, 8'h20);

    phase = "R9";
    wr(0, 8'h81);
    raise(8'h0C); do_ack(); raise(8'h01); do_ack(); rd_all();
    wr(0, 8'hE2); rd_all();
    raise(8'h48); idle(1); do_ack(); idle(1); rd_all();
    wr(0, 8'hE0); wr(0, 8'hE3); wr(0, 8'hE6); rd_all();

    phase = "R12";
    @(negedge clk); cs_n = 1; rd_n = 0; #1;
    expect_bit("R12 dout zero without select", dout == 8'h00, 1'b1);
    rd_n = 1; cs_n = 0; #1;
    expect_bit("R12 dout zero without read", dout == 8'h00, 1'b1);
    cs_n = 1;
    wr(0, 8'h00); wr(0, 8'h7F); rd_all();

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule